// File: doc/BRIEF.md
# Two-Wide Instruction Dispatcher with Resource Gating

This block sits between the instruction queue and the execution units. Each cycle it looks at the two oldest decoded instructions. It decides how many of them, zero, one or two, may leave the queue that cycle. Every instruction names one target execution unit and a five-bit mask of the register classes it writes. An instruction leaves only when three conditions hold: its unit reports a free slot, every class it writes has a free rename register, and the completion queue has room.

The block owns the rename free lists and the completion-queue allocation pointer. The rename pools hold six general-purpose tags, six floating-point tags, and one tag each for the condition, link and count registers. When an instruction dispatches, the block hands out rename tags and a completion-queue index in that same cycle. Tags come back through a release mask. Completion-queue entries come back through a retire count.

Dispatch is strictly in order. If the older instruction cannot leave, the younger one waits as well. A flush input blocks all dispatch and all allocation for as long as it is high.

Top module: `dual_dispatch`

## Requirements
- R1: At most two instructions dispatch per cycle. `disp_vld[1]` (younger, slot 1) is set only when `disp_vld[0]` (older, slot 0) is set in the same cycle. A valid slot 1 behind an invalid slot 0 does not dispatch.
- R2: A slot dispatches only if `unit_free[unit]` is high for its target unit. `iq_unit` packs slot 0 in bits [1:0] and slot 1 in bits [3:2].
- R3: If both slots name the same unit, only slot 0 may dispatch that cycle.
- R4: `iq_dst` packs slot 0 in bits [4:0] and slot 1 in bits [9:5]. The mask bits are bit0 general, bit1 floating, bit2 condition, bit3 link, bit4 count. The pool sizes are 6, 6, 1, 1 and 1. A slot dispatches only if every class in its mask has a free tag. Pools are independent of each other.
- R5: When both slots write the same class, their combined demand is compared with that pool's free count before either is granted. For example, with the single condition tag free, only slot 0 dispatches.
- R6: Slot 0 needs one free completion-queue entry. Slot 1 also needs a second one. The queue has 6 entries and starts empty.
- R7: Slot 0 gets the lowest-numbered free tag of a class, and slot 1 gets the next free one. A granted tag stays busy until its bit is set in `rel_mask`. Bit `c*6+t` of `rel_mask` frees tag t of class c, and the tag is available from the next cycle. `disp_tag` packs the tag for slot s and class c at bits `(s*5+c)*3` and is zero where nothing is allocated.
- R8: Slot 0 gets the completion index at the tail and slot 1 gets the following index. Indices wrap from 5 to 0. `disp_cq_idx` packs slot 0 in bits [2:0] and slot 1 in bits [5:3]. Each cycle, `cq_retire` entries are released, limited to the current occupancy.
- R9: While `flush` is high, `disp_vld` is zero and no tag or completion entry is consumed.
- R10: After reset, all tags are free, the completion queue is empty with its tail at 0, and all outputs are zero when no slot is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Blocks dispatch and allocation |
| iq_vld | input | 2 | Queue slot valid, bit 0 is oldest |
| iq_unit | input | 4 | Target unit index per slot |
| iq_dst | input | 10 | Destination class mask per slot |
| unit_free | input | 4 | Vacancy flag per execution unit |
| rel_mask | input | 30 | Rename tags returned this cycle |
| cq_retire | input | 2 | Completion entries retired this cycle |
| disp_vld | output | 2 | Dispatch strobe per slot |
| disp_tag | output | 30 | Allocated rename tags per slot and class |
| disp_cq_idx | output | 6 | Completion-queue index per slot |

## Verification
Two things can collide in the same cycle: the in-order stall caused by a resource the older instruction lacks, and the contention between the two slots for a shared unit or a shared single-entry pool. The bench provokes the collision with pairs that target the same unit, pairs that both write the condition register, and pairs where only one of the two units is vacant. It judges each case by whether exactly slot 0, both slots, or neither dispatched. Further sequences drain the general pool and fill the completion queue, then check the stall point, the wrap of the completion index, and which tag comes back after a release.

// File: rtl/dispatch_pkg.sv
// Package: shared sizes for the dual dispatcher.
// Assumes five rename classes in a fixed bit order: general, floating,
// condition, link, count.
package dispatch_pkg;
    localparam int NCLS     = 5;
    localparam int CLS_GPR  = 0;
    localparam int CLS_FPR  = 1;
    localparam int CLS_CR   = 2;
    localparam int CLS_LR   = 3;
    localparam int CLS_CTR  = 4;
    localparam int GPR_TAGS = 6;
    localparam int FPR_TAGS = 6;
    localparam int PMAX     = (GPR_TAGS > FPR_TAGS) ? GPR_TAGS : FPR_TAGS;
    localparam int TAGW     = $clog2(PMAX);
    localparam int CNTW     = $clog2(PMAX + 1);

    // Number of tags held by the pool of class c.
    function automatic int pool_depth(input int c);
        if (c == CLS_GPR) return GPR_TAGS;
        if (c == CLS_FPR) return FPR_TAGS;
        return 1;
    endfunction
endpackage

// File: rtl/rename_pool.sv
// Module: free list for one rename class.
// Gives out the lowest free tag to the older slot and the next free tag to the
// younger slot. Released tags become free from the following cycle.
// Assumes the requester never takes more tags than free_cnt reports.
module rename_pool #(
    parameter int DEPTH = 6,
    parameter int TAGW  = 3,
    parameter int CNTW  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take0,
    input  logic             take1,
    input  logic [DEPTH-1:0] rel,
    output logic [CNTW-1:0]  free_cnt,
    output logic [TAGW-1:0]  tag_s0,
    output logic [TAGW-1:0]  tag_s1
);
    logic [DEPTH-1:0] free_q;
    logic [DEPTH-1:0] clr;
    logic [TAGW-1:0]  first_t;
    logic [TAGW-1:0]  second_t;
    logic             got0;
    logic             got1;

    // Find the first two free tags and count the free ones.
    always_comb begin
        first_t  = '0;
        second_t = '0;
        got0     = 1'b0;
        got1     = 1'b0;
        free_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (free_q[i]) begin
                free_cnt = free_cnt + CNTW'(1);
                if (!got0) begin
                    first_t = TAGW'(i);
                    got0    = 1'b1;
                end else if (!got1) begin
                    second_t = TAGW'(i);
                    got1     = 1'b1;
                end
            end
        end
    end

    assign tag_s0 = first_t;
    assign tag_s1 = take0 ? second_t : first_t;

    // Build the mask of tags consumed this cycle.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            clr[i] = (take0 && (tag_s0 == TAGW'(i))) ||
                     (take1 && (tag_s1 == TAGW'(i)));
        end
    end

    // Update the free bitmap: consume grants, return releases.
    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= (free_q & ~clr) | rel;
    end
endmodule

// File: rtl/cq_alloc.sv
// Module: completion-queue slot allocator.
// Tracks the tail index and the occupancy of a circular queue. Up to two
// entries are taken and any number are retired per cycle; retirement is
// limited to the occupancy held before this cycle's allocation.
module cq_alloc #(
    parameter int DEPTH = 6,
    parameter int IW    = 3,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    take_cnt,
    input  logic [1:0]    retire,
    output logic [IW-1:0] idx0,
    output logic [IW-1:0] idx1,
    output logic [CW-1:0] free_cnt
);
    logic [IW-1:0] tail_q;
    logic [CW-1:0] occ_q;
    logic [CW-1:0] ret_eff;
    int            tail_sum;

    // Indices handed to the two slots; the second one wraps.
    assign idx0     = tail_q;
    assign idx1     = (tail_q == IW'(DEPTH - 1)) ? '0 : tail_q + IW'(1);
    assign free_cnt = CW'(DEPTH) - occ_q;

    // Clip the retire count and work out the advanced tail.
    always_comb begin
        ret_eff  = (CW'(retire) > occ_q) ? occ_q : CW'(retire);
        tail_sum = int'(tail_q) + int'(take_cnt);
        if (tail_sum >= DEPTH) tail_sum = tail_sum - DEPTH;
    end

    // Register tail and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            tail_q <= IW'(tail_sum);
            occ_q  <= occ_q - ret_eff + CW'(take_cnt);
        end
    end
endmodule

// File: rtl/dispatch_arbiter.sv
// Module: per-cycle dispatch decision.
// Grants the older slot when its unit, every needed rename pool and one
// completion entry are available; grants the younger slot only on top of
// that, on a different unit, with combined pool demand and two entries.
module dispatch_arbiter #(
    parameter int NUM_UNITS = 4,
    parameter int UW        = 2,
    parameter int NCLS      = 5,
    parameter int CNTW      = 3,
    parameter int CQCW      = 3
) (
    input  logic                 flush,
    input  logic [1:0]           vld,
    input  logic [UW-1:0]        unit0,
    input  logic [UW-1:0]        unit1,
    input  logic [NCLS-1:0]      dst0,
    input  logic [NCLS-1:0]      dst1,
    input  logic [NUM_UNITS-1:0] unit_free,
    input  logic [NCLS*CNTW-1:0] pool_free,
    input  logic [CQCW-1:0]      cq_free,
    output logic                 go0,
    output logic                 go1
);
    logic [NCLS-1:0] ok_old;
    logic [NCLS-1:0] ok_pair;

    // Per-class checks: alone for the older slot, summed for the pair.
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        logic [CNTW-1:0] avail;
        logic [CNTW-1:0] need;
        assign avail      = pool_free[c*CNTW +: CNTW];
        assign need       = CNTW'(dst0[c]) + CNTW'(dst1[c]);
        assign ok_old[c]  = !dst0[c] || (avail != '0);
        assign ok_pair[c] = need <= avail;
    end

    // In-order grant: the younger slot rides on the older one.
    always_comb begin
        go0 = !flush && vld[0] && unit_free[unit0] && (&ok_old) &&
              (cq_free >= CQCW'(1));
        go1 = go0 && vld[1] && unit_free[unit1] && (unit1 != unit0) &&
              (&ok_pair) && (cq_free >= CQCW'(2));
    end
endmodule

// File: rtl/dual_dispatch.sv
// Module: two-wide dispatch with unit, rename and completion gating (top).
// Decides the grants, allocates rename tags from per-class pools and
// completion-queue indices in the same cycle, and presents them on the outputs.
// Assumes NUM_UNITS is a power of two and the queue presents its oldest
// instruction in slot 0.
module dual_dispatch
    import dispatch_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int CQ_DEPTH  = 6,
    localparam int UW       = $clog2(NUM_UNITS),
    localparam int CQIW     = $clog2(CQ_DEPTH),
    localparam int CQCW     = $clog2(CQ_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic [1:0]             iq_vld,
    input  logic [2*UW-1:0]        iq_unit,
    input  logic [2*NCLS-1:0]      iq_dst,
    input  logic [NUM_UNITS-1:0]   unit_free,
    input  logic [NCLS*PMAX-1:0]   rel_mask,
    input  logic [1:0]             cq_retire,
    output logic [1:0]             disp_vld,
    output logic [2*NCLS*TAGW-1:0] disp_tag,
    output logic [2*CQIW-1:0]      disp_cq_idx
);
    logic [NCLS-1:0]      dst0;
    logic [NCLS-1:0]      dst1;
    logic [NCLS*CNTW-1:0] pool_free;
    logic [CQCW-1:0]      cq_free;
    logic [CQIW-1:0]      cq_i0;
    logic [CQIW-1:0]      cq_i1;
    logic                 go0;
    logic                 go1;
    logic [1:0]           take_cnt;

    assign dst0 = iq_dst[NCLS-1:0];
    assign dst1 = iq_dst[2*NCLS-1:NCLS];

    dispatch_arbiter #(
        .NUM_UNITS (NUM_UNITS),
        .UW        (UW),
        .NCLS      (NCLS),
        .CNTW      (CNTW),
        .CQCW      (CQCW)
    ) u_arb (
        .flush     (flush),
        .vld       (iq_vld),
        .unit0     (iq_unit[UW-1:0]),
        .unit1     (iq_unit[2*UW-1:UW]),
        .dst0      (dst0),
        .dst1      (dst1),
        .unit_free (unit_free),
        .pool_free (pool_free),
        .cq_free   (cq_free),
        .go0       (go0),
        .go1       (go1)
    );

    // One free list per rename class, sized from the package.
    for (genvar c = 0; c < NCLS; c++) begin : g_pool
        localparam int DEPTH = pool_depth(c);
        logic            take0;
        logic            take1;
        logic [TAGW-1:0] t0;
        logic [TAGW-1:0] t1;
        assign take0 = go0 && dst0[c];
        assign take1 = go1 && dst1[c];
        rename_pool #(
            .DEPTH    (DEPTH),
            .TAGW     (TAGW),
            .CNTW     (CNTW)
        ) u_pool (
            .clk      (clk),
            .rst_n    (rst_n),
            .take0    (take0),
            .take1    (take1),
            .rel      (rel_mask[c*PMAX +: DEPTH]),
            .free_cnt (pool_free[c*CNTW +: CNTW]),
            .tag_s0   (t0),
            .tag_s1   (t1)
        );
        assign disp_tag[c*TAGW +: TAGW]        = take0 ? t0 : '0;
        assign disp_tag[(NCLS+c)*TAGW +: TAGW] = take1 ? t1 : '0;
    end

    assign take_cnt = {1'b0, go0} + {1'b0, go1};

    cq_alloc #(
        .DEPTH    (CQ_DEPTH),
        .IW       (CQIW),
        .CW       (CQCW)
    ) u_cq (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_cnt (take_cnt),
        .retire   (cq_retire),
        .idx0     (cq_i0),
        .idx1     (cq_i1),
        .free_cnt (cq_free)
    );

    assign disp_vld    = {go1, go0};
    assign disp_cq_idx = {go1 ? cq_i1 : '0, go0 ? cq_i0 : '0};
endmodule

// File: rtl/dual_dispatch_chk.sv
// Module: protocol checker attached to dual_dispatch by bind.
// Observes ports only and flags grants that break ordering, vacancy,
// unit, single-pool, index or flush rules.
module dual_dispatch_chk #(
    parameter int NUM_UNITS = 4,
    parameter int CQ_DEPTH  = 6,
    parameter int NCLS      = 5,
    localparam int UW       = $clog2(NUM_UNITS),
    localparam int CQIW     = $clog2(CQ_DEPTH)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic [2*UW-1:0]      iq_unit,
    input logic [2*NCLS-1:0]    iq_dst,
    input logic [NUM_UNITS-1:0] unit_free,
    input logic [1:0]           disp_vld,
    input logic [2*CQIW-1:0]    disp_cq_idx
);
    logic [UW-1:0]   u0;
    logic [UW-1:0]   u1;
    logic [CQIW-1:0] i0;
    logic [CQIW-1:0] i1;
    assign u0 = iq_unit[UW-1:0];
    assign u1 = iq_unit[2*UW-1:UW];
    assign i0 = disp_cq_idx[CQIW-1:0];
    assign i1 = disp_cq_idx[2*CQIW-1:CQIW];

    assert_in_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld[1] |-> disp_vld[0]);

    assert_unit_vacant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld[0] |-> unit_free[u0]);

    assert_distinct_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (&disp_vld) |-> (u0 != u1) && unit_free[u1]);

    assert_single_cr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (&disp_vld) |-> !(iq_dst[2] && iq_dst[NCLS+2]));

    assert_cq_consecutive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&disp_vld) |-> (i1 == ((i0 == CQIW'(CQ_DEPTH - 1)) ? '0 : i0 + CQIW'(1))));

    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (disp_vld == 2'b00));
endmodule

bind dual_dispatch dual_dispatch_chk #(
    .NUM_UNITS (NUM_UNITS),
    .CQ_DEPTH  (CQ_DEPTH),
    .NCLS      (dispatch_pkg::NCLS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .iq_unit     (iq_unit),
    .iq_dst      (iq_dst),
    .unit_free   (unit_free),
    .disp_vld    (disp_vld),
    .disp_cq_idx (disp_cq_idx)
);

// File: tb/dual_dispatch_bench.sv
module dual_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush;
    logic [1:0]  iq_vld;
    logic [3:0]  iq_unit;
    logic [9:0]  iq_dst;
    logic [3:0]  unit_free;
    logic [29:0] rel_mask;
    logic [1:0]  cq_retire;
    logic [1:0]  disp_vld;
    logic [29:0] disp_tag;
    logic [5:0]  disp_cq_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_dispatch u_dual_dispatch (
        .clk (clk), .rst_n (rst_n), .flush (flush), .iq_vld (iq_vld),
        .iq_unit (iq_unit), .iq_dst (iq_dst), .unit_free (unit_free),
        .rel_mask (rel_mask), .cq_retire (cq_retire), .disp_vld (disp_vld),
        .disp_tag (disp_tag), .disp_cq_idx (disp_cq_idx)
    );

    // Vector: {vld[21:20], u0[19:18], u1[17:16], d0[15:11], d1[10:6], free[5:2], exp[1:0]}
    localparam logic [21:0] VEC [12] = '{
        {2'b01, 2'd0, 2'd0, 5'b00001, 5'b00000, 4'b1111, 2'b01},
        {2'b11, 2'd0, 2'd1, 5'b00001, 5'b00001, 4'b1111, 2'b11},
        {2'b11, 2'd0, 2'd0, 5'b00001, 5'b00001, 4'b1111, 2'b01},
        {2'b11, 2'd0, 2'd1, 5'b00001, 5'b00001, 4'b1110, 2'b00},
        {2'b11, 2'd0, 2'd1, 5'b00001, 5'b00001, 4'b1101, 2'b01},
        {2'b11, 2'd0, 2'd1, 5'b00100, 5'b00100, 4'b1111, 2'b01},
        {2'b11, 2'd0, 2'd1, 5'b01000, 5'b10000, 4'b1111, 2'b11},
        {2'b10, 2'd0, 2'd1, 5'b00001, 5'b00001, 4'b1111, 2'b00},
        {2'b00, 2'd0, 2'd1, 5'b00001, 5'b00001, 4'b1111, 2'b00},
        {2'b11, 2'd2, 2'd3, 5'b00011, 5'b00011, 4'b1111, 2'b11},
        {2'b11, 2'd2, 2'd3, 5'b11100, 5'b11100, 4'b1111, 2'b01},
        {2'b11, 2'd3, 2'd2, 5'b00000, 5'b00000, 4'b0011, 2'b00}
    };
    localparam string VREQ [12] = '{"R1", "R1", "R3", "R2", "R2", "R5",
                                    "R4", "R1", "R1", "R4", "R5", "R2"};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int tag_of(input int s, input int c);
        return int'(disp_tag[(s*5+c)*3 +: 3]);
    endfunction

    // Drive one cycle's inputs after the falling edge, settle, then leave.
    task automatic drive(input logic [1:0] v, input logic [1:0] u0, input logic [1:0] u1,
                         input logic [4:0] d0, input logic [4:0] d1, input logic [3:0] uf,
                         input logic [29:0] rel, input logic [1:0] ret, input logic fl);
        @(negedge clk);
        iq_vld = v; iq_unit = {u1, u0}; iq_dst = {d1, d0}; unit_free = uf;
        rel_mask = rel; cq_retire = ret; flush = fl;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        iq_vld = '0; iq_unit = '0; iq_dst = '0; unit_free = '1;
        rel_mask = '0; cq_retire = '0; flush = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        do_reset();
        // R10: quiet outputs after reset
        drive(2'b00, 0, 0, 0, 0, 4'hf, 0, 0, 0);
        check("R10 idle vld", int'(disp_vld), 0);
        check("R10 idle tags", int'(disp_tag != 0), 0);

        // Table walk, each vector from a fresh reset state
        for (int k = 0; k < 12; k++) begin
            logic [21:0] v;
            v = VEC[k];
            do_reset();
            drive(v[21:20], v[19:18], v[17:16], v[15:11], v[10:6], v[5:2], 0, 0, 0);
            check(VREQ[k], int'(disp_vld), int'(v[1:0]));
        end

        // R7/R4/R8: drain the general pool while retiring completion entries
        do_reset();
        drive(2'b11, 0, 1, 5'b00001, 5'b00001, 4'hf, 0, 0, 0);
        check("R10 first tag", tag_of(0, 0), 0);
        check("R7 slot1 tag", tag_of(1, 0), 1);
        check("R8 idx pair", int'(disp_cq_idx), (1 << 3) | 0);
        drive(2'b11, 0, 1, 5'b00001, 5'b00001, 4'hf, 0, 2, 0);
        check("R7 tags 2/3", tag_of(0, 0) * 10 + tag_of(1, 0), 23);
        drive(2'b11, 0, 1, 5'b00001, 5'b00001, 4'hf, 0, 2, 0);
        check("R7 tags 4/5", tag_of(0, 0) * 10 + tag_of(1, 0), 45);
        check("R8 idx 4/5", int'(disp_cq_idx), (5 << 3) | 4);
        drive(2'b01, 0, 1, 5'b00001, 5'b00000, 4'hf, 0, 2, 0);
        check("R4 general pool empty", int'(disp_vld), 0);
        drive(2'b01, 1, 0, 5'b00010, 5'b00000, 4'hf, 0, 0, 0);
        check("R4 other pool independent", int'(disp_vld), 1);
        check("R8 index wraps", int'(disp_cq_idx[2:0]), 0);
        check("R7 floating tag", tag_of(0, 1), 0);
        drive(2'b00, 0, 0, 0, 0, 4'hf, 30'd1 << 3, 0, 0);
        check("R7 release cycle idle", int'(disp_vld), 0);
        drive(2'b01, 0, 1, 5'b00001, 5'b00000, 4'hf, 0, 0, 0);
        check("R7 released tag reused", tag_of(0, 0), 3);
        check("R8 next index", int'(disp_cq_idx[2:0]), 1);

        // R6: fill the completion queue with destination-less pairs
        do_reset();
        for (int k = 0; k < 3; k++) begin
            drive(2'b11, 0, 1, 0, 0, 4'hf, 0, 0, 0);
            check("R6 fill", int'(disp_vld), 3);
        end
        drive(2'b11, 0, 1, 0, 0, 4'hf, 0, 0, 0);
        check("R6 queue full", int'(disp_vld), 0);
        drive(2'b00, 0, 1, 0, 0, 4'hf, 0, 1, 0);
        drive(2'b11, 0, 1, 0, 0, 4'hf, 0, 0, 0);
        check("R6 one entry only", int'(disp_vld), 1);
        check("R8 index after wrap", int'(disp_cq_idx), 0);

        // R9: flush blocks dispatch and allocation
        do_reset();
        drive(2'b11, 0, 1, 5'b00001, 5'b00001, 4'hf, 0, 0, 1);
        check("R9 flush vld", int'(disp_vld), 0);
        drive(2'b11, 0, 1, 5'b00001, 5'b00001, 4'hf, 0, 0, 0);
        check("R9 nothing consumed tags", tag_of(0, 0) * 10 + tag_of(1, 0), 1);
        check("R9 nothing consumed index", int'(disp_cq_idx), (1 << 3) | 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule